// File: doc/BRIEF.md
# Binary FSK Tone Modulator for 1200 bit/s Signalling

This block turns a serial bit stream into a binary frequency-shift-keyed tone for 1200 bit/s asynchronous links. A 24-bit phase accumulator runs on a 3.579545 MHz reference clock. A logic 1 (mark) selects a 1300 Hz step and a logic 0 (space) selects a 2100 Hz step. The top bits of the phase are shaped into an unsigned sample word, which an external DAC and reconstruction filter take.

A two-bit mode input picks the behaviour. The modes are a sleep state with the output parked at mid-scale, a continuous mark tone, a continuous space tone, and data modulation. In data modulation, a select input chooses whether the keyed bit comes from the raw data pin or from an already retimed bit. The frequency changes only by changing the phase step, so the waveform has no phase jump at a bit edge.

The controller has four states, and each state is named after the mode that selects it: `ST_SLEEP` (mode 00), `ST_MARK` (mode 01), `ST_SPACE` (mode 10) and `ST_MOD` (mode 11). On every clock edge the state moves to the state named by the current mode. Any state can therefore move to any other state in one cycle, and a state stays as it is while the mode is unchanged.

Top module: `fsk_tone_mod`

## Requirements
- R1: While reset is asserted and after it is released with mode 00, `tone_on` is 0, `tone_is_space` is 0 and `sample` is 128, which is mid-scale for 8 bits.
- R2: Mode 00 (sleep) sets `tone_on` to 0 at the next edge and clears the accumulator. `sample` is 128 at the edge after that and stays there until a tone mode is selected.
- R3: Mode 01 produces only the mark tone with a phase step of 6093. The data inputs and the select input have no effect.
- R4: Mode 10 produces only the space tone with a phase step of 9843. The data inputs and the select input have no effect.
- R5: In mode 11 a keyed bit of 1 selects the mark step and a keyed bit of 0 selects the space step. The keyed bit is registered, so it takes effect one edge after it is presented, and `tone_is_space` shows the step in use.
- R6: In mode 11, `use_retimed`=1 takes the keyed bit from `data_retimed` and `use_retimed`=0 takes it from `data_raw`.
- R7: The accumulator is never reset at a frequency change. While a tone is on, the phase advances by exactly the selected step each cycle, modulo 2^24, so `sample` moves by at most 1 code between cycles.
- R8: With the default triangle shape, let p be the top 9 bits of the phase. `sample` is p[7:0] when p[8]=0 and ~p[7:0] when p[8]=1. It is registered one cycle after the phase.
- R9: The measured mark and space tone frequencies are within 1% of 1300 Hz and 2100 Hz at a 3.579545 MHz clock.
- R10: A change of mode is reflected on `tone_on` and `tone_is_space` at the first clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, nominally 3.579545 MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 sleep, 01 mark only, 10 space only, 11 data modulation |
| data_raw | input | 1 | Unretimed data bit |
| data_retimed | input | 1 | Data bit from the retiming stage |
| use_retimed | input | 1 | Selects the retimed bit in data modulation |
| sample | output | 8 | Unsigned waveform sample for the DAC |
| tone_on | output | 1 | A tone is being generated |
| tone_is_space | output | 1 | The space step is in use |

## Verification
The bench switches the keyed bit in the middle of a tone and checks that the sample steps by no more than one code. A design that cleared or re-seeded the phase at a bit edge would show a jump there. It toggles both data inputs and the select input during the forced-tone modes, and a design that let data leak through would raise `tone_is_space` or diverge from the model. It enters sleep from a running tone and later leaves it again, which catches an accumulator that is not cleared or an output that is not parked at mid-scale. It also times ten zero crossings of each tone, so a wrong phase step shows up as a frequency error beyond 1%.

// File: rtl/fsk_pkg.sv
package fsk_pkg;

    typedef enum logic [1:0] {
        ST_SLEEP = 2'b00,
        ST_MARK  = 2'b01,
        ST_SPACE = 2'b10,
        ST_MOD   = 2'b11
    } fsk_state_e;

endpackage

// File: rtl/fsk_mode_fsm.sv
module fsk_mode_fsm
    import fsk_pkg::*;
#(
    parameter int ACC_W = 24,
    parameter logic [ACC_W-1:0] MARK_STEP = '0,
    parameter logic [ACC_W-1:0] SPACE_STEP = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             key_bit,
    output fsk_state_e       state,
    output logic [ACC_W-1:0] step,
    output logic             active,
    output logic             is_space
);

    fsk_state_e state_q;
    fsk_state_e state_d;
    logic       bit_q;

    // next-state decode: every state follows the mode pins
    always_comb begin
        unique case (mode)
            2'b00:   state_d = ST_SLEEP;
            2'b01:   state_d = ST_MARK;
            2'b10:   state_d = ST_SPACE;
            default: state_d = ST_MOD;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SLEEP;
            bit_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            bit_q   <= key_bit;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_SLEEP: begin
                active   = 1'b0;
                is_space = 1'b0;
                step     = '0;
            end
            ST_MARK: begin
                active   = 1'b1;
                is_space = 1'b0;
                step     = MARK_STEP;
            end
            ST_SPACE: begin
                active   = 1'b1;
                is_space = 1'b1;
                step     = SPACE_STEP;
            end
            ST_MOD: begin
                active   = 1'b1;
                is_space = ~bit_q;
                step     = bit_q ? MARK_STEP : SPACE_STEP;
            end
            default: begin
                active   = 1'b0;
                is_space = 1'b0;
                step     = '0;
            end
        endcase
    end

    assign state = state_q;

    assert_step_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (step == MARK_STEP || step == SPACE_STEP));

endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc #(
    parameter int ACC_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [ACC_W-1:0] step,
    output logic [ACC_W-1:0] phase
);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase <= '0;
        end else begin
            phase <= phase + step;
        end
    end

    assert_clear_in_sleep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (phase == '0));

endmodule

// File: rtl/fsk_wave_gen.sv
module fsk_wave_gen #(
    parameter int SW  = 8,
    parameter bit TRI = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [SW:0]   ph_top,
    output logic [SW-1:0] sample
);

    localparam logic [SW-1:0] MID = SW'(1) << (SW - 1);

    logic [SW-1:0] shaped;

    generate
        if (TRI) begin : g_tri
            assign shaped = ph_top[SW] ? ~ph_top[SW-1:0] : ph_top[SW-1:0];
        end else begin : g_sq
            assign shaped = ph_top[SW] ? '1 : '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            sample <= MID;
        end else begin
            sample <= shaped;
        end
    end

endmodule

// File: rtl/fsk_tone_mod.sv
module fsk_tone_mod
    import fsk_pkg::*;
#(
    parameter int ACC_W    = 24,
    parameter int SW       = 8,
    parameter int CLK_HZ   = 3579545,
    parameter int MARK_HZ  = 1300,
    parameter int SPACE_HZ = 2100,
    parameter bit TRI      = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          data_raw,
    input  logic          data_retimed,
    input  logic          use_retimed,
    output logic [SW-1:0] sample,
    output logic          tone_on,
    output logic          tone_is_space
);

    localparam logic [63:0] FULL   = 64'd1 << ACC_W;
    localparam logic [63:0] MARK64 = (64'(MARK_HZ) * FULL + 64'(CLK_HZ / 2)) / 64'(CLK_HZ);
    localparam logic [63:0] SPC64  = (64'(SPACE_HZ) * FULL + 64'(CLK_HZ / 2)) / 64'(CLK_HZ);
    localparam logic [ACC_W-1:0] MARK_STEP  = MARK64[ACC_W-1:0];
    localparam logic [ACC_W-1:0] SPACE_STEP = SPC64[ACC_W-1:0];
    localparam logic [SW-1:0]    MID        = SW'(1) << (SW - 1);

    fsk_state_e       state;
    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] phase;
    logic             key_bit;

    assign key_bit = use_retimed ? data_retimed : data_raw;

    fsk_mode_fsm #(
        .ACC_W(ACC_W), .MARK_STEP(MARK_STEP), .SPACE_STEP(SPACE_STEP)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .mode(mode), .key_bit(key_bit),
        .state(state), .step(step), .active(tone_on), .is_space(tone_is_space)
    );

    fsk_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .run(tone_on), .step(step), .phase(phase)
    );

    fsk_wave_gen #(.SW(SW), .TRI(TRI)) u_wave (
        .clk(clk), .rst_n(rst_n), .en(tone_on),
        .ph_top(phase[ACC_W-1 -: SW+1]), .sample(sample)
    );

    assert_sleep_mid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP) |=> (sample == MID));

    assert_phase_cont_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tone_on && $past(tone_on)) |-> (phase == $past(phase) + $past(step)));

    assert_mark_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |=> (tone_on && !tone_is_space));

    assert_space_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |=> (tone_on && tone_is_space));

    assert_sleep_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> !tone_on);

endmodule

// File: tb/fsk_tone_mod_tb.sv
module fsk_tone_mod_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       data_raw = 1'b0;
    logic       data_retimed = 1'b0;
    logic       use_retimed = 1'b0;
    logic [7:0] sample;
    logic       tone_on;
    logic       tone_is_space;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit cmp_en = 1'b0;

    // model state
    int   m_state = 0;
    bit   m_bit = 1'b1;
    int   m_acc = 0;
    int   m_sample = 128;

    always #2 clk = ~clk;

    fsk_tone_mod u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .data_raw(data_raw),
        .data_retimed(data_retimed), .use_retimed(use_retimed),
        .sample(sample), .tone_on(tone_on), .tone_is_space(tone_is_space)
    );

    function automatic int tri_of(int acc);
        int p;
        p = (acc >> 15) & 511;
        return (p >= 256) ? (255 - (p & 255)) : (p & 255);
    endfunction

    function automatic int step_of(int st, bit b);
        if (st == 1) return 6093;
        if (st == 2) return 9843;
        if (st == 3) return b ? 6093 : 9843;
        return 0;
    endfunction

    // behavioural reference, updated on every edge
    always @(posedge clk) begin
        int n_sample;
        int n_acc;
        cyc++;
        if (!rst_n) begin
            m_state  = 0;
            m_bit    = 1'b1;
            m_acc    = 0;
            m_sample = 128;
        end else begin
            n_sample = (m_state == 0) ? 128 : tri_of(m_acc);
            n_acc    = (m_state == 0) ? 0 : ((m_acc + step_of(m_state, m_bit)) & 24'hFFFFFF);
            m_state  = int'(mode);
            m_bit    = use_retimed ? data_retimed : data_raw;
            m_sample = n_sample;
            m_acc    = n_acc;
        end
    end

    // cycle-by-cycle comparison (R7, R8)
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            tests++;
            if (int'(sample) != m_sample || tone_on != (m_state != 0) ||
                tone_is_space != (m_state == 2 || (m_state == 3 && !m_bit))) begin
                fails++;
                $display("FAIL R8 cycle %0d: sample=%0d on=%0b sp=%0b expected sample=%0d state=%0d",
                         cyc, sample, tone_on, tone_is_space, m_sample, m_state);
            end
        end
    end

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 190000 && !done) begin
            fails++;
            $display("FAIL watchdog: actual=%0d expected<190000", cyc);
            finish_run();
        end
    end

    // times ten rising mid-scale crossings, returns frequency in mHz
    task automatic measure(output int mhz);
        int prev;
        int start;
        int n;
        prev = int'(sample);
        n = -1;
        start = 0;
        while (n < 10) begin
            @(negedge clk);
            if (prev < 128 && int'(sample) >= 128) begin
                if (n < 0) start = cyc;
                n++;
            end
            prev = int'(sample);
        end
        mhz = int'(10.0 * 3579545.0 * 1000.0 / real'(cyc - start));
    endtask

    task automatic check_freq(string req, int mhz, int target_hz);
        tests++;
        if (mhz < target_hz * 990 || mhz > target_hz * 1010) begin
            fails++;
            $display("FAIL %s: actual=%0d mHz expected=%0d mHz +-1%%", req, mhz, target_hz * 1000);
        end
    endtask

    initial begin
        int f;
        int prev;
        int maxd;
        repeat (4) @(negedge clk);
        check("R1 reset tone_on", int'(tone_on), 0);
        check("R1 reset sample", int'(sample), 128);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle sample", int'(sample), 128);
        check("R1 idle space flag", int'(tone_is_space), 0);

        // R3 mark only, data toggling ignored
        mode = 2'b01;
        @(negedge clk);
        check("R10 mark entry tone_on", int'(tone_on), 1);
        maxd = 0;
        for (int i = 0; i < 400; i++) begin
            data_raw = i[0]; data_retimed = i[1]; use_retimed = i[2];
            @(negedge clk);
            if (tone_is_space) maxd = 1;
        end
        check("R3 data ignored in mark", maxd, 0);
        measure(f);
        check_freq("R9 R3 mark freq", f, 1300);

        // R4 space only
        mode = 2'b10;
        @(negedge clk);
        check("R10 space entry", int'(tone_is_space), 1);
        maxd = 1;
        for (int i = 0; i < 400; i++) begin
            data_raw = i[1]; data_retimed = i[0]; use_retimed = i[2];
            @(negedge clk);
            if (!tone_is_space) maxd = 0;
        end
        check("R4 data ignored in space", maxd, 1);
        measure(f);
        check_freq("R9 R4 space freq", f, 2100);

        // R5 R6 data modulation, R7 continuity
        mode = 2'b11; use_retimed = 1'b0; data_raw = 1'b1; data_retimed = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R5 raw 1 gives mark", int'(tone_is_space), 0);
        use_retimed = 1'b1;
        @(negedge clk);
        check("R6 retimed 0 gives space", int'(tone_is_space), 1);
        maxd = 0;
        prev = int'(sample);
        for (int i = 0; i < 6000; i++) begin
            if (i % 2983 == 0) data_retimed = ~data_retimed;
            @(negedge clk);
            if (int'(sample) - prev > maxd) maxd = int'(sample) - prev;
            if (prev - int'(sample) > maxd) maxd = prev - int'(sample);
            prev = int'(sample);
        end
        check("R7 max sample step", (maxd <= 1) ? 1 : 0, 1);
        data_raw = 1'b0;
        @(negedge clk);
        check("R6 raw ignored when retimed selected", int'(tone_is_space), data_retimed ? 0 : 1);

        // R2 sleep from running tone, then resume
        mode = 2'b00;
        @(negedge clk);
        check("R2 sleep tone_on", int'(tone_on), 0);
        @(negedge clk);
        check("R2 sleep mid-scale", int'(sample), 128);
        repeat (50) @(negedge clk);
        check("R2 sleep holds", int'(sample), 128);
        mode = 2'b01;
        repeat (2) @(negedge clk);
        check("R2 resume from zero phase", int'(sample), 0);
        repeat (200) @(negedge clk);
        finish_run();
    end

endmodule